// File: doc/BRIEF.md
# Two-Level Interrupt Priority Acknowledger

This block serves one processor of a multi-processor interrupt controller. It looks at the interrupt bits that are outstanding for its processor and picks the most urgent one. A bit is outstanding if it is pending and routed to this processor, or forced for this processor. The block reports the winner as a trap vector. When the processor later acknowledges that vector, the block decides which state bit the acknowledge retires. It then issues a single-cycle clear strobe to the register file that holds those bits. The register file and the bus access to it live outside this block.

Urgency uses two levels. A per-interrupt level bit promotes an interrupt above every unpromoted one. Inside a level, the larger interrupt number wins. Extended sources sit above the base range. They all share the urgency of interrupt 1 and are reported as interrupt 1. When interrupt 1 is acknowledged, the block picks one outstanding extended source and publishes its number. The processor's request line is registered. After an acknowledge that retires a bit, the line drops and is held low long enough for the register file to apply the clear. It is then re-evaluated.

Top module: `irq_prio_ack`

## Requirements
- R1: An outstanding base interrupt whose `level_i` bit is 1 wins over every outstanding interrupt whose level bit is 0, whatever their numbers.
- R2: Among outstanding base interrupts with the same level bit, the one with the larger number wins.
- R3: Any outstanding extended source (bit index 16 and up) competes as interrupt 1 at level 0, and is reported as vector 0x11 when it wins.
- R4: `vec_o` is combinational and equals the winning interrupt number plus 0x10. It is 0 when nothing is outstanding. Bit 0 of every input vector never counts as outstanding.
- R5: An acknowledge (`ack_valid_i` high, `ack_vec_i` = number + 0x10) whose target has its force bit set raises only that bit in `force_clr_o`. It raises nothing in `pend_clr_o`, even if the pending bit is also set.
- R6: With the force bit clear, the pending bit of the target is cleared only if it is set and `live_i` for that number is 0.
- R7: An acknowledge of vector 0x11 while extended sources are outstanding targets the lowest-numbered one. It writes that number on `ext_ack_num_o` with `ext_ack_we_o` high and applies the R5/R6 rules to that source's bits.
- R8: An acknowledge of vector 0x11 with no extended source outstanding writes 0 on `ext_ack_num_o` with `ext_ack_we_o` high, and applies R5/R6 to interrupt 1 itself.
- R9: `irq_o` rises on the clock edge after something becomes outstanding. After an acknowledge that clears a bit, it is low for exactly two cycles and then reflects the remaining outstanding bits.
- R10: An acknowledge that targets no set force bit and no clearable pending bit leaves `irq_o` unchanged and raises no clear strobe. The same holds for a vector of 0x10 or below.
- R11: Clear strobes and `ext_ack_we_o` appear on the clock edge that samples the acknowledge. They last one cycle and are one-hot or zero across both clear vectors together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | 16+NUM_EXT | Global pending bits already masked for this processor |
| force_i | input | 16+NUM_EXT | This processor's force bits |
| live_i | input | 16+NUM_EXT | Present state of the interrupt inputs |
| level_i | input | 16 | Level bit per base interrupt (1 = upper level) |
| ack_valid_i | input | 1 | Acknowledge strobe from the processor |
| ack_vec_i | input | 5 | Vector being acknowledged |
| vec_o | output | 5 | Trap vector of the current winner, 0 if none |
| irq_o | output | 1 | Registered request line to the processor |
| force_clr_o | output | 16+NUM_EXT | One-cycle clear strobe for force bits |
| pend_clr_o | output | 16+NUM_EXT | One-cycle clear strobe for global pending bits |
| ext_ack_we_o | output | 1 | Write strobe for the extended-acknowledge record |
| ext_ack_num_o | output | 5 | Value for the extended-acknowledge record |

## Verification
`vec_o` has no register in its path, so the bench drives inputs on a falling edge and reads the vector a nanosecond later. An acknowledge is driven on a falling edge and captured by the next rising edge. Its strobes and extended-acknowledge write are read at the falling edge that follows, and one more falling edge later they must be gone. The request line is read one falling edge after a new bit appears. After a retiring acknowledge it is read on each of the next three falling edges, so the two low cycles and the re-evaluation all land on the cycles where they are due.

// File: rtl/ipa_pkg.sv
package ipa_pkg;
    // Number of base interrupts; numbering beyond this is extended.
    localparam int BASE_N  = 16;
    localparam int BASE_IW = $clog2(BASE_N);
    // Vector = number + BASE_N, so one more bit than a base number.
    localparam int VEC_W   = BASE_IW + 1;
    // Urgency key: {level bit, number}.
    localparam int KEY_W   = BASE_IW + 1;

    function automatic logic [VEC_W-1:0] to_vector(input logic [BASE_IW-1:0] num);
        return (num == '0) ? '0 : {1'b1, num};
    endfunction
endpackage

// File: rtl/ipa_select.sv
module ipa_select
    import ipa_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0]   pend_i,
    input  logic [NSRC-1:0]   force_i,
    input  logic [BASE_N-1:0] level_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic              any_o
);
    logic [NSRC-1:0]  act;
    logic [KEY_W-1:0] key [BASE_N];
    logic [KEY_W-1:0] best;
    logic             ext_any;

    assign act     = pend_i | force_i;
    assign ext_any = |act[NSRC-1:BASE_N];

    // Per-interrupt urgency key; number 0 never competes.
    for (genvar g = 0; g < BASE_N; g++) begin : g_key
        assign key[g] = (g != 0 && act[g]) ? {level_i[g], BASE_IW'(g)} : '0;
    end

    // Extended sources enter with the key of interrupt 1 at level 0.
    always_comb begin
        best = ext_any ? KEY_W'(1) : '0;
        for (int i = 1; i < BASE_N; i++) begin
            if (key[i] > best) best = key[i];
        end
    end

    assign any_o = (best != '0);
    assign vec_o = to_vector(best[BASE_IW-1:0]);
endmodule

// File: rtl/ipa_clear.sv
module ipa_clear
    import ipa_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic              ack_valid_i,
    input  logic [VEC_W-1:0]  ack_vec_i,
    input  logic [NSRC-1:0]   pend_i,
    input  logic [NSRC-1:0]   force_i,
    input  logic [NSRC-1:0]   live_i,
    output logic [NSRC-1:0]   fclr_o,
    output logic [NSRC-1:0]   pclr_o,
    output logic              xwe_o,
    output logic [IDX_W-1:0]  xnum_o,
    output logic              hit_o
);
    logic [NSRC-1:0]    act;
    logic               num_ok;
    logic [BASE_IW-1:0] base_num;
    logic               is_one;
    logic               ext_found;
    logic [IDX_W-1:0]   ext_idx;
    logic [IDX_W-1:0]   target;

    assign act      = pend_i | force_i;
    assign base_num = ack_vec_i[BASE_IW-1:0];
    assign num_ok   = ack_valid_i && ack_vec_i[VEC_W-1] && (base_num != '0);
    assign is_one   = num_ok && (base_num == BASE_IW'(1));

    // Lowest-numbered outstanding extended source.
    always_comb begin
        ext_found = 1'b0;
        ext_idx   = '0;
        for (int i = NSRC - 1; i >= BASE_N; i--) begin
            if (act[i]) begin
                ext_found = 1'b1;
                ext_idx   = IDX_W'(i);
            end
        end
    end

    assign target = (is_one && ext_found) ? ext_idx : IDX_W'(base_num);

    always_comb begin
        fclr_o = '0;
        pclr_o = '0;
        if (num_ok) begin
            if (force_i[target])
                fclr_o[target] = 1'b1;
            else if (pend_i[target] && !live_i[target])
                pclr_o[target] = 1'b1;
        end
    end

    assign xwe_o  = is_one;
    assign xnum_o = ext_found ? ext_idx : '0;
    assign hit_o  = (fclr_o != '0) || (pclr_o != '0);
endmodule

// File: rtl/irq_prio_ack.sv
module irq_prio_ack
    import ipa_pkg::*;
#(
    parameter int NUM_EXT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [BASE_N+NUM_EXT-1:0]  pend_i,
    input  logic [BASE_N+NUM_EXT-1:0]  force_i,
    input  logic [BASE_N+NUM_EXT-1:0]  live_i,
    input  logic [BASE_N-1:0]          level_i,
    input  logic                       ack_valid_i,
    input  logic [VEC_W-1:0]           ack_vec_i,
    output logic [VEC_W-1:0]           vec_o,
    output logic                       irq_o,
    output logic [BASE_N+NUM_EXT-1:0]  force_clr_o,
    output logic [BASE_N+NUM_EXT-1:0]  pend_clr_o,
    output logic                       ext_ack_we_o,
    output logic [$clog2(BASE_N+NUM_EXT)-1:0] ext_ack_num_o
);
    localparam int NSRC  = BASE_N + NUM_EXT;
    localparam int IDX_W = $clog2(NSRC);

    typedef struct packed {
        logic             irq;
        logic             hold;
        logic [NSRC-1:0]  fclr;
        logic [NSRC-1:0]  pclr;
        logic             xwe;
        logic [IDX_W-1:0] xnum;
    } state_t;

    state_t st_d, st_q;

    logic              any_w;
    logic [NSRC-1:0]   fclr_w, pclr_w;
    logic              xwe_w, hit_w;
    logic [IDX_W-1:0]  xnum_w;

    ipa_select #(.NSRC(NSRC)) u_sel (
        .pend_i  (pend_i),
        .force_i (force_i),
        .level_i (level_i),
        .vec_o   (vec_o),
        .any_o   (any_w)
    );

    ipa_clear #(.NSRC(NSRC), .IDX_W(IDX_W)) u_clr (
        .ack_valid_i (ack_valid_i),
        .ack_vec_i   (ack_vec_i),
        .pend_i      (pend_i),
        .force_i     (force_i),
        .live_i      (live_i),
        .fclr_o      (fclr_w),
        .pclr_o      (pclr_w),
        .xwe_o       (xwe_w),
        .xnum_o      (xnum_w),
        .hit_o       (hit_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.fclr = fclr_w;
        st_d.pclr = pclr_w;
        st_d.xwe  = xwe_w;
        if (xwe_w) st_d.xnum = xnum_w;
        // Drop on a retiring acknowledge, stay low while the clear lands.
        st_d.hold = hit_w;
        st_d.irq  = !(hit_w || st_q.hold) && any_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o         = st_q.irq;
    assign force_clr_o   = st_q.fclr;
    assign pend_clr_o    = st_q.pclr;
    assign ext_ack_we_o  = st_q.xwe;
    assign ext_ack_num_o = st_q.xnum;

    // R11
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.fclr, st_q.pclr}));

    // R11
    strobe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack_valid_i) |-> (st_q.fclr == '0 && st_q.pclr == '0 && !st_q.xwe));

    // R6
    no_live_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pclr != '0) |-> ((st_q.pclr & $past(live_i)) == '0));

    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w |=> !irq_o);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit_w, 2) |-> !irq_o);

    // R8
    xack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ack_we_o |-> ($past(ack_vec_i) == VEC_W'(BASE_N + 1)));

    // R4
    vec_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o != '0) |-> vec_o[VEC_W-1]);
endmodule

// File: tb/irq_prio_ack_test.sv
module irq_prio_ack_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pend_i = '0, force_i = '0, live_i = '0;
    logic [15:0] level_i = '0;
    logic        ack_valid_i = 1'b0;
    logic [4:0]  ack_vec_i = '0;
    logic [4:0]  vec_o;
    logic        irq_o;
    logic [31:0] force_clr_o, pend_clr_o;
    logic        ext_ack_we_o;
    logic [4:0]  ext_ack_num_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_prio_ack uut (
        .clk(clk), .rst_n(rst_n),
        .pend_i(pend_i), .force_i(force_i), .live_i(live_i), .level_i(level_i),
        .ack_valid_i(ack_valid_i), .ack_vec_i(ack_vec_i),
        .vec_o(vec_o), .irq_o(irq_o),
        .force_clr_o(force_clr_o), .pend_clr_o(pend_clr_o),
        .ext_ack_we_o(ext_ack_we_o), .ext_ack_num_o(ext_ack_num_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] p, input logic [31:0] f,
                         input logic [31:0] l, input logic [15:0] lv);
        @(negedge clk);
        pend_i = p; force_i = f; live_i = l; level_i = lv;
        #1;
    endtask

    // Drive an acknowledge for one capture edge; returns at the following falling edge.
    task automatic ack(input logic [4:0] v);
        @(negedge clk);
        ack_valid_i = 1'b1; ack_vec_i = v;
        @(negedge clk);
        ack_valid_i = 1'b0; ack_vec_i = '0;
        #1;
    endtask

    task automatic t_reset;
        check("R4 reset vec", vec_o, 0);
        check("R9 reset irq", irq_o, 0);
        check("R11 reset strobes", force_clr_o | pend_clr_o, 0);
        check("R11 reset xwe", ext_ack_we_o, 0);
    endtask

    task automatic t_levels;
        drive(32'h1008, 0, 0, 16'h0008);
        check("R1 level1 low number wins", vec_o, 5'h13);
        drive(32'h1008, 0, 0, 16'h0000);
        check("R2 level0 higher number", vec_o, 5'h1C);
        drive(32'h1008, 0, 0, 16'h1008);
        check("R2 level1 higher number", vec_o, 5'h1C);
        drive(32'h0010, 32'h0200, 0, 16'h0010);
        check("R1 forced level0 loses", vec_o, 5'h14);
    endtask

    task automatic t_ext;
        drive(32'h0010_0000, 0, 0, 0);
        check("R3 ext alone", vec_o, 5'h11);
        drive(32'h0010_0004, 0, 0, 0);
        check("R3 ext loses to 2", vec_o, 5'h12);
        drive(32'h0000_0001, 32'h0000_0001, 0, 16'hFFFF);
        check("R4 bit0 ignored", vec_o, 0);
        drive(0, 0, 0, 0);
        check("R4 none", vec_o, 0);
    endtask

    task automatic t_irq;
        drive(32'h0080, 0, 0, 0);
        @(negedge clk); #1;
        check("R9 irq rises", irq_o, 1);
        ack(5'h17);
        check("R6 pend clear", pend_clr_o, 32'h0080);
        check("R9 irq dropped", irq_o, 0);
        pend_i = 32'h0200;
        @(negedge clk); #1;
        check("R11 strobe one cycle", pend_clr_o, 0);
        check("R9 irq still low", irq_o, 0);
        @(negedge clk); #1;
        check("R9 irq re-evaluated", irq_o, 1);
        check("R2 new winner", vec_o, 5'h19);
    endtask

    task automatic t_force;
        drive(32'h0020, 32'h0020, 0, 0);
        @(negedge clk);
        ack(5'h15);
        check("R5 force cleared", force_clr_o, 32'h0020);
        check("R5 pend untouched", pend_clr_o, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_live;
        drive(32'h0040, 0, 32'h0040, 0);
        repeat (3) @(negedge clk);
        ack(5'h16);
        check("R6 live blocks clear", pend_clr_o | force_clr_o, 0);
        check("R10 irq kept", irq_o, 1);
        live_i = 0;
        ack(5'h16);
        check("R6 clear after input drops", pend_clr_o, 32'h0040);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_ext_ack;
        drive(32'h0204_0000, 0, 0, 0);
        @(negedge clk);
        ack(5'h11);
        check("R7 xwe", ext_ack_we_o, 1);
        check("R7 lowest ext", ext_ack_num_o, 18);
        check("R7 ext pend clear", pend_clr_o, 32'h0004_0000);
        drive(32'h0002, 0, 0, 0);
        check("R11 xwe one cycle", ext_ack_we_o, 0);
        ack(5'h11);
        check("R8 xwe", ext_ack_we_o, 1);
        check("R8 record zero", ext_ack_num_o, 0);
        check("R8 clears int1", pend_clr_o, 32'h0002);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_nomatch;
        drive(32'h0008, 0, 0, 0);
        repeat (3) @(negedge clk);
        ack(5'h1A);
        check("R10 unmatched strobes", pend_clr_o | force_clr_o, 0);
        check("R10 unmatched irq", irq_o, 1);
        ack(5'h10);
        check("R10 vec 0x10", {pend_clr_o | force_clr_o, 31'(ext_ack_we_o)}, 0);
        ack(5'h05);
        check("R10 low vec strobes", pend_clr_o | force_clr_o, 0);
        check("R10 low vec irq", irq_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_levels();
        t_ext();
        t_irq();
        t_force();
        t_live();
        t_ext_ack();
        t_nomatch();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule